// File: doc/BRIEF.md
# Configuration Bitstream Header Stripper and Serializer

This block sits between a byte source that delivers an FPGA configuration file and the slave-serial configuration port of the device being loaded. The file opens with a header of variable length that the device must never see. The block consumes header bytes silently while it searches for the true start of the bitstream. That start is a 0xFF fill byte followed directly by a preamble byte whose upper nibble is 0x2. From the fill byte onward, every byte goes out unchanged on a serial data line, most significant bit first, with a configuration clock generated from the system clock by a programmable divider.

The byte input uses a valid/ready handshake and has an end-of-file marker on the final byte. Ready stays low while a byte is shifted, so the source is throttled to the serial rate. The 24-bit length count carried at the front of the bitstream is captured on the way and reported once all of its bytes have arrived. A done flag reports a completed transfer. An error flag reports a file that ends before any start pattern appears.

Top module: `bitstream_feeder`

## Requirements
- R1: Bytes taken before the start pattern produce no configuration clock edges, and in/ready stays 1 while searching.
- R2: A 0xFF byte followed immediately by a byte whose bits [7:4] equal 0x2 marks the start, whatever the low nibble (0x20 and 0x21 both accepted). Both bytes are sent, so the first twelve serial bits are 1111_1111_0010.
- R3: A 0xFF byte not followed by a 0x2X byte emits nothing and the search continues. In a run of 0xFF bytes, the last one before the 0x2X byte is the fill byte that gets sent.
- R4: Every byte from the fill byte to the end of file is sent unchanged, 8 bits per byte, MSB first. Each bit is valid at a rising edge of serClk.
- R5: serData only changes while serClk is low. It never changes during a high phase.
- R6: Each high phase of serClk lasts halfDiv+1 system clock cycles.
- R7: inReady is 0 while a byte is being shifted. A new byte is taken only after all 8 bits of the previous byte have been clocked out.
- R8: After the byte flagged with inLast has been fully shifted, done rises and stays at 1, and no further serClk edges occur.
- R9: If inLast arrives before any start pattern, error rises and stays at 1, and serClk never toggles.
- R10: lenCount[23:20] takes the low nibble of the preamble byte, lenCount[19:12] the next byte and lenCount[11:4] the byte after that, with lenCount[3:0] zero. lenValid rises when the third of these bytes is accepted, and the value then holds.
- R11: After reset, inReady=1, serClk=0, done=0, error=0 and lenValid=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfDiv | input | DIV_W | Length of each serClk phase, minus one, in system clocks |
| inData | input | 8 | File byte |
| inValid | input | 1 | inData holds a byte |
| inLast | input | 1 | This byte is the last byte of the file |
| inReady | output | 1 | Block accepts the byte on this cycle |
| serData | output | 1 | Serial configuration data |
| serClk | output | 1 | Configuration clock |
| done | output | 1 | Whole bitstream sent |
| error | output | 1 | File ended without a start pattern |
| lenCount | output | 24 | Captured length count |
| lenValid | output | 1 | lenCount is complete |

## Verification
The bench keeps the default DIV_W and sweeps halfDiv from 0 to 3 on one realistic file, which makes every serial phase short enough to run all cases in a few thousand cycles. It also covers single-cycle phases, where the data change and the falling edge coincide. Further files exercise a doubled fill byte, fill bytes followed by a non-preamble byte, a file with no start at all, and a file that ends on its preamble byte before the length is complete. Expected serial bits, start offset and length count are derived from each byte array by the bench.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

  localparam int BYTE_W = 8;
  localparam int LEN_W  = 24;
  localparam logic [BYTE_W-1:0] FILL_BYTE    = 8'hFF;
  localparam logic [3:0]        PREAMBLE_NIB = 4'h2;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_SHIFT,
    ST_FETCH,
    ST_DONE,
    ST_FAIL
  } feedState_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic trackByte;     // header byte seen, remember whether it was a fill byte
    logic captureStart;  // start found: send fill byte, hold preamble as pending
    logic loadInput;     // shift the byte on inData
    logic loadPending;   // shift the held preamble byte
    logic lenByte;       // byte belongs to the length field candidates
  } feedCmd_t;

endpackage

// File: rtl/feeder_dp.sv
module feeder_dp
  import feeder_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  feedCmd_t          cmd,
  input  logic [BYTE_W-1:0] inData,
  input  logic [DIV_W-1:0]  halfDiv,
  output logic              serData,
  output logic              serClk,
  output logic              byteDone,
  output logic              pendValid,
  output logic              prevFill,
  output logic [LEN_W-1:0]  lenCount,
  output logic              lenValid
);

  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int LEN_IDXW = 2;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] pendReg;
  logic [BIT_W-1:0]  bitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              phaseHigh;
  logic              active;
  logic [LEN_IDXW-1:0] lenIdx;
  logic [LEN_W-1:0]  lenReg;

  logic phaseEnd;
  logic anyLoad;

  assign phaseEnd = active && (divCnt == halfDiv);
  assign byteDone = phaseEnd && phaseHigh && (bitCnt == LAST_BIT);
  assign anyLoad  = cmd.captureStart | cmd.loadInput | cmd.loadPending;

  // fill-byte tracker for the start search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFill <= 1'b0;
    end else if (cmd.captureStart) begin
      prevFill <= 1'b0;
    end else if (cmd.trackByte) begin
      prevFill <= (inData == FILL_BYTE);
    end
  end

  // shift engine and phase divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      pendReg   <= '0;
      pendValid <= 1'b0;
      bitCnt    <= '0;
      divCnt    <= '0;
      phaseHigh <= 1'b0;
      active    <= 1'b0;
    end else if (anyLoad) begin
      active    <= 1'b1;
      bitCnt    <= '0;
      divCnt    <= '0;
      phaseHigh <= 1'b0;
      if (cmd.captureStart) begin
        shReg     <= FILL_BYTE;
        pendReg   <= inData;
        pendValid <= 1'b1;
      end else if (cmd.loadInput) begin
        shReg <= inData;
      end else begin
        shReg     <= pendReg;
        pendValid <= 1'b0;
      end
    end else if (active) begin
      if (phaseEnd) begin
        divCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          if (bitCnt == LAST_BIT) begin
            active <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            shReg  <= {shReg[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign serData = shReg[BYTE_W-1];
  assign serClk  = phaseHigh;

  // length field capture: preamble nibble, then two whole bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenIdx   <= '0;
      lenReg   <= '0;
      lenValid <= 1'b0;
    end else if (cmd.lenByte && !lenValid) begin
      lenIdx <= lenIdx + 1'b1;
      case (lenIdx)
        2'd0:    lenReg[LEN_W-1 -: 4]             <= inData[3:0];
        2'd1:    lenReg[LEN_W-5 -: BYTE_W]        <= inData;
        default: begin
          lenReg[LEN_W-5-BYTE_W -: BYTE_W] <= inData;
          lenValid <= 1'b1;
        end
      endcase
    end
  end

  assign lenCount = lenReg;

endmodule

// File: rtl/feeder_ctrl.sv
module feeder_ctrl
  import feeder_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  input  logic [3:0] inHighNib,
  input  logic     byteDone,
  input  logic     pendValid,
  input  logic     prevFill,
  output feedCmd_t cmd,
  output logic     inReady,
  output logic     done,
  output logic     error
);

  feedState_t state, stateNext;
  logic eofSeen;
  logic eofSet;

  always_comb begin
    cmd       = '0;
    inReady   = 1'b0;
    stateNext = state;
    eofSet    = 1'b0;
    case (state)
      ST_SEARCH: begin
        inReady = 1'b1;
        if (inValid) begin
          if (prevFill && (inHighNib == PREAMBLE_NIB)) begin
            cmd.captureStart = 1'b1;
            cmd.lenByte      = 1'b1;
            eofSet           = inLast;
            stateNext        = ST_SHIFT;
          end else begin
            cmd.trackByte = 1'b1;
            if (inLast) stateNext = ST_FAIL;
          end
        end
      end
      ST_SHIFT: begin
        if (byteDone) begin
          if (pendValid)    cmd.loadPending = 1'b1;
          else if (eofSeen) stateNext = ST_DONE;
          else              stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        inReady = 1'b1;
        if (inValid) begin
          cmd.loadInput = 1'b1;
          cmd.lenByte   = 1'b1;
          eofSet        = inLast;
          stateNext     = ST_SHIFT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      eofSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (eofSet) eofSeen <= 1'b1;
    end
  end

  assign done  = (state == ST_DONE);
  assign error = (state == ST_FAIL);

endmodule

// File: rtl/bitstream_feeder.sv
module bitstream_feeder
  import feeder_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             serData,
  output logic             serClk,
  output logic             done,
  output logic             error,
  output logic [23:0]      lenCount,
  output logic             lenValid
);

  feedCmd_t cmd;
  logic byteDone;
  logic pendValid;
  logic prevFill;

  feeder_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .inHighNib (inData[7:4]),
    .byteDone  (byteDone),
    .pendValid (pendValid),
    .prevFill  (prevFill),
    .cmd       (cmd),
    .inReady   (inReady),
    .done      (done),
    .error     (error)
  );

  feeder_dp #(.DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .inData    (inData),
    .halfDiv   (halfDiv),
    .serData   (serData),
    .serClk    (serClk),
    .byteDone  (byteDone),
    .pendValid (pendValid),
    .prevFill  (prevFill),
    .lenCount  (lenCount),
    .lenValid  (lenValid)
  );

endmodule

// File: rtl/feeder_checker.sv
module feeder_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inReady,
  input logic        serData,
  input logic        serClk,
  input logic        done,
  input logic        error,
  input logic [23:0] lenCount,
  input logic        lenValid
);

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData)); // R5

  AST_NO_READY_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> !inReady); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && !serClk)); // R8

  AST_DONE_NOT_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R8

  AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    error |=> (error && !serClk && !inReady)); // R9

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    lenValid |=> (lenValid && $stable(lenCount))); // R10

  AST_LEN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    lenValid |-> (lenCount[3:0] == 4'h0)); // R10

endmodule

bind bitstream_feeder feeder_checker chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .serData  (serData),
  .serClk   (serClk),
  .done     (done),
  .error    (error),
  .lenCount (lenCount),
  .lenValid (lenValid)
);

// File: tb/bitstream_feeder_test.sv
module bitstream_feeder_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0] halfDiv = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic inReady, serData, serClk, done, error, lenValid;
  logic [23:0] lenCount;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic [7:0] strm [0:63];
  int strmN;
  logic capBits [0:1023];
  int rises = 0;
  int hiRun = 0;
  int widthBad = 0;
  int boundaryBad = 0;

  bitstream_feeder #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rstN(rstN), .halfDiv(halfDiv),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .serData(serData), .serClk(serClk), .done(done), .error(error),
    .lenCount(lenCount), .lenValid(lenValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge serClk) begin
    if (rises < 1024) capBits[rises] = serData;
    rises = rises + 1;
  end

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (serClk) hiRun = hiRun + 1;
    else begin
      if (hiRun > 0 && hiRun != int'(halfDiv) + 1) widthBad = widthBad + 1;
      hiRun = 0;
    end
    if (cycles > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input int div);
    rstN = 1'b0;
    inValid = 1'b0;
    inLast = 1'b0;
    halfDiv = DIV_W'(div);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rises = 0;
    widthBad = 0;
    boundaryBad = 0;
    hiRun = 0;
  endtask

  task automatic sendStream();
    for (int i = 0; i < strmN; i++) begin
      inData = strm[i];
      inValid = 1'b1;
      inLast = (i == strmN - 1);
      while (!inReady) @(negedge clk);
      if ((rises % 8) != 0) boundaryBad = boundaryBad + 1;
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic runCase(input string name, input int div);
    int startIdx;
    int expBits;
    int bitErr;
    int waitN;
    int risesAfter;
    logic [23:0] expLen;
    bit expLenValid;
    startIdx = -1;
    for (int i = 1; i < strmN; i++)
      if (startIdx < 0 && strm[i-1] == 8'hFF && strm[i][7:4] == 4'h2) startIdx = i - 1;
    doReset(div);
    sendStream();
    waitN = 0;
    while (!done && !error && waitN < 30000) begin
      @(negedge clk);
      waitN++;
    end
    if (startIdx < 0) begin
      check(error && !done, {name, " R9 error flag"}, {error, done}, 2'b10);
      check(rises == 0, {name, " R9/R1 no serial clocks"}, rises, 0);
      check(!lenValid, {name, " R10 no length"}, lenValid, 0);
      return;
    end
    expBits = (strmN - startIdx) * 8;
    check(done && !error, {name, " R8 done"}, {done, error}, 2'b10);
    check(rises == expBits, {name, " R4/R1 serial bit count"}, rises, expBits);
    bitErr = 0;
    for (int j = 0; j < expBits && j < 1024; j++)
      if (capBits[j] !== strm[startIdx + j/8][7 - j%8]) bitErr++;
    check(bitErr == 0, {name, " R4/R3 serial bits MSB first"}, bitErr, 0);
    check(expBits >= 16 && {capBits[0], capBits[1], capBits[2], capBits[3],
                            capBits[4], capBits[5], capBits[6], capBits[7],
                            capBits[8], capBits[9], capBits[10], capBits[11]} == 12'hFF2,
          {name, " R2 leading pattern"},
          {capBits[8], capBits[9], capBits[10], capBits[11]}, 4'h2);
    check(widthBad == 0, {name, " R6 high phase width"}, widthBad, 0);
    check(boundaryBad == 0, {name, " R7 byte taken on byte boundary"}, boundaryBad, 0);
    expLenValid = (startIdx + 3 < strmN);
    expLen = '0;
    if (expLenValid)
      expLen = {strm[startIdx+1][3:0], strm[startIdx+2], strm[startIdx+3], 4'h0};
    check(lenValid == expLenValid, {name, " R10 length valid"}, lenValid, expLenValid);
    if (expLenValid) check(lenCount == expLen, {name, " R10 length count"}, lenCount, expLen);
    risesAfter = rises;
    repeat (40) @(negedge clk);
    check(rises == risesAfter && done, {name, " R8 quiet after done"}, rises, risesAfter);
  endtask

  initial begin
    doReset(1);
    check(inReady && !serClk && !done && !error && !lenValid, "R11 reset state",
          {inReady, serClk, done, error, lenValid}, 5'b10000);

    // header with tags and a lone fill byte, then the bitstream
    strmN = 22;
    {strm[0], strm[1], strm[2], strm[3], strm[4], strm[5], strm[6], strm[7],
     strm[8], strm[9], strm[10], strm[11], strm[12], strm[13], strm[14], strm[15],
     strm[16], strm[17], strm[18], strm[19], strm[20], strm[21]} =
      {8'h00, 8'h09, 8'h0F, 8'hF0, 8'h61, 8'h00, 8'h02, 8'h41, 8'h42, 8'h65, 8'h00,
       8'h01, 8'hFF, 8'h46, 8'hFF, 8'h20, 8'hA3, 8'h21, 8'h1F, 8'h5F, 8'hF7, 8'hEF};
    for (int d = 0; d < 4; d++) runCase($sformatf("hdr div%0d", d), d);

    // doubled fill byte before a 0x21 preamble
    strmN = 8;
    {strm[0], strm[1], strm[2], strm[3], strm[4], strm[5], strm[6], strm[7]} =
      {8'h12, 8'hFF, 8'hFF, 8'h21, 8'h00, 8'h04, 8'h80, 8'h3C};
    runCase("double fill", 2);

    // fill bytes followed by non-preamble bytes, file ends without start
    strmN = 7;
    {strm[0], strm[1], strm[2], strm[3], strm[4], strm[5], strm[6]} =
      {8'h61, 8'h00, 8'hFF, 8'h30, 8'hFF, 8'h7E, 8'h00};
    runCase("no start", 1);

    // file ends on the preamble byte
    strmN = 3;
    {strm[0], strm[1], strm[2]} = {8'h33, 8'hFF, 8'h20};
    runCase("short tail", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule